// File: doc/BRIEF.md
# Five-Channel Double-Buffered Down-Counter Timer

This block holds five independent down-counting timers behind a simple synchronous register port. Software writes a reload value, and a compare value for the first four channels, into buffer registers. It moves them into the working counter by holding a per-channel load bit. Then it clears that bit and sets the channel's run bit. Each channel counts down by one on every cycle in which its tick enable from the external prescaler is high.

On expiry, a channel either reloads from its buffer and keeps counting, or it parks at zero. If its interrupt enable is set, the channel records a sticky status bit, and software clears that bit by writing one to it. The first four channels also drive a waveform output. It rises when the count reaches the compare value and falls on reload, and its polarity can be inverted.

All five channels share one control word. Its layout is irregular: the nibble after channel 0 is left empty, and the last channel has no invert bit, so its reload-mode bit moves down by one place.

Top module: `quint_timer`

## Requirements
- R1: After reset, every register reads zero, every live count is zero, and all interrupt and waveform outputs are low.
- R2: The control word at 0x08 gives channel 0 bits [3:0] and channel c≥1 bits [4c+7:4c+4]. Within a nibble, bit 0 is run, bit 1 is load, bit 2 is invert and bit 3 is auto-reload. Channel 4 has only run (bit 20), load (bit 21) and auto-reload (bit 22). Unimplemented bits read 0, so writing all ones reads back 0x007FFF0F.
- R3: In every cycle in which a channel's load bit is set, its counter takes the reload buffer and its compare register takes the compare buffer. The counter does not count while load is set, even with run set.
- R4: With run set and load clear, the counter drops by one on each cycle in which its tick enable is high. It holds its value when the tick enable is low.
- R5: A tick that arrives while the count is zero is an expiry. With auto-reload clear, the counter then stays at zero and raises no further expiry until the next load.
- R6: With auto-reload set, an expiry reloads the counter from its reload buffer, so a reload value N gives one expiry every N+1 ticks.
- R7: For c = 0..4 the reload buffer is at 0x0C+12c. For c = 0..3 the compare buffer is at 0x10+12c. The live count is at 0x14+12c for c = 0..3 and at 0x40 for channel 4. Writes to live-count addresses change nothing.
- R8: The interrupt word at 0x44 holds enables in bits [4:0] and status in bits [9:5]. An expiry sets its status bit only while that channel's enable is set. Each interrupt output is high exactly while its enable and status bits are both 1.
- R9: A write to 0x44 loads the enable bits directly. It clears each status bit written with 1 and leaves status bits written with 0 unchanged.
- R10: When a clear-by-write of a status bit and an expiry of the same enabled channel fall in the same cycle, the status bit ends set.
- R11: Each waveform level goes to 1 when a decrement lands on the compare value and returns to 0 on reload or load. The output is that level XOR the invert bit. Channel 4 has no compare buffer and uses a fixed compare of zero, without inversion.
- R12: Buffer writes keep the low CNT_W bits, so writing all ones to a reload buffer reads back 2^CNT_W − 1 (0xFFFF at the default width of 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for regAddr, combinational |
| tickEn | input | 5 | Per-channel count enables from the prescaler |
| irqOut | output | 5 | Per-channel interrupt lines |
| toggleOut | output | 5 | Per-channel waveform outputs |

## Verification
Two events can meet in one cycle: a status-clearing write and a fresh expiry of the same channel. The bench times a write-one-to-clear so that its capturing edge is the exact edge on which a one-shot count of 3 expires. It expects the interrupt line to stay high afterwards, and a following clear to drop it. A second overlap is a buffer write on a reload edge, where the reload must take the buffer's old value. The checker covers that overlap on every channel by comparing the reloaded count with the previous cycle's buffer.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Channel count is fixed by the irregular control layout.
  localparam int NUM_CH    = 5;
  localparam int ADDR_CTRL = 'h08;
  localparam int ADDR_IRQ  = 'h44;
  localparam int ST_LSB    = 5;
  localparam logic [31:0] CTRL_MASK = 32'h007F_FF0F;

  // Start bit of a channel's nibble in the control word.
  function automatic int nibBase(input int c);
    return (c == 0) ? 0 : 4 * (c + 1);
  endfunction

  // Auto-reload bit; it moves down one place for the last channel.
  function automatic int arBit(input int c);
    return (c == NUM_CH - 1) ? nibBase(c) + 2 : nibBase(c) + 3;
  endfunction

  function automatic int cntAddr(input int c);
    return 'h0C + 12 * c;
  endfunction

  function automatic int cmpAddr(input int c);
    return 'h10 + 12 * c;
  endfunction

  function automatic int liveAddr(input int c);
    return (c == NUM_CH - 1) ? 'h40 : 'h14 + 12 * c;
  endfunction

  // Strobes and levels sent from the register control to each channel.
  typedef struct packed {
    logic start;
    logic manual;
    logic invert;
    logic autoRld;
    logic wrCnt;
    logic wrCmp;
  } chanCtl_t;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [NUM_CH-1:0] expire,
  input  logic [CNT_W-1:0]  liveCnt [NUM_CH],
  input  logic [CNT_W-1:0]  cntBuf  [NUM_CH],
  input  logic [CNT_W-1:0]  cmpBuf  [NUM_CH],
  output chanCtl_t          chCtl   [NUM_CH],
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] irqEn,
  output logic [NUM_CH-1:0] irqOut
);

  localparam logic [DATA_W-1:0] WMASK = DATA_W'(CTRL_MASK);

  logic [DATA_W-1:0] ctrlQ;
  logic [NUM_CH-1:0] irqEnQ;
  logic [NUM_CH-1:0] irqStQ;
  logic [NUM_CH-1:0] stClr;
  logic              wrCtrl;
  logic              wrIrq;

  assign wrCtrl = regWr && (regAddr == ADDR_W'(ADDR_CTRL));
  assign wrIrq  = regWr && (regAddr == ADDR_W'(ADDR_IRQ));
  assign stClr  = wrIrq ? regWdata[ST_LSB +: NUM_CH] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (wrCtrl) begin
      ctrlQ <= regWdata & WMASK;
    end
  end

  // A new expiry wins over a clear written in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnQ <= '0;
      irqStQ <= '0;
    end else begin
      if (wrIrq) irqEnQ <= regWdata[NUM_CH-1:0];
      irqStQ <= (irqStQ & ~stClr) | (expire & irqEnQ);
    end
  end

  assign irqEn  = irqEnQ;
  assign irqOut = irqEnQ & irqStQ;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      chCtl[c].start   = ctrlQ[nibBase(c)];
      chCtl[c].manual  = ctrlQ[nibBase(c) + 1];
      chCtl[c].invert  = (c < NUM_CH - 1) ? ctrlQ[nibBase(c) + 2] : 1'b0;
      chCtl[c].autoRld = ctrlQ[arBit(c)];
      chCtl[c].wrCnt   = regWr && (regAddr == ADDR_W'(cntAddr(c)));
      chCtl[c].wrCmp   = (c < NUM_CH - 1) && regWr &&
                         (regAddr == ADDR_W'(cmpAddr(c)));
    end
  end

  always_comb begin
    rdData = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) rdData = ctrlQ;
    if (regAddr == ADDR_W'(ADDR_IRQ)) begin
      rdData[NUM_CH-1:0]         = irqEnQ;
      rdData[ST_LSB +: NUM_CH]   = irqStQ;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (regAddr == ADDR_W'(cntAddr(c))) rdData = DATA_W'(cntBuf[c]);
      if ((c < NUM_CH - 1) && (regAddr == ADDR_W'(cmpAddr(c))))
        rdData = DATA_W'(cmpBuf[c]);
      if (regAddr == ADDR_W'(liveAddr(c))) rdData = DATA_W'(liveCnt[c]);
    end
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanCtl_t         ctl,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  output logic [CNT_W-1:0] liveCnt,
  output logic [CNT_W-1:0] cntBufQ,
  output logic [CNT_W-1:0] cmpBufQ,
  output logic             expire,
  output logic             toggleOut
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic [CNT_W-1:0] cntDec;
  logic             toggleRaw;
  logic             done;
  logic             running;

  assign running = ctl.start && !ctl.manual && !done;
  assign expire  = running && tick && (cnt == '0);
  assign cntDec  = cnt - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntBufQ <= '0;
      cmpBufQ <= '0;
    end else begin
      if (ctl.wrCnt) cntBufQ <= wdata;
      if (ctl.wrCmp) cmpBufQ <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      cmp       <= '0;
      toggleRaw <= 1'b0;
      done      <= 1'b0;
    end else if (ctl.manual) begin
      cnt       <= cntBufQ;
      cmp       <= cmpBufQ;
      toggleRaw <= 1'b0;
      done      <= 1'b0;
    end else if (running && tick) begin
      if (cnt == '0) begin
        if (ctl.autoRld) begin
          cnt       <= cntBufQ;
          cmp       <= cmpBufQ;
          toggleRaw <= 1'b0;
        end else begin
          done <= 1'b1;
        end
      end else begin
        cnt <= cntDec;
        if (cntDec == cmp) toggleRaw <= 1'b1;
      end
    end
  end

  assign liveCnt   = cnt;
  assign toggleOut = toggleRaw ^ ctl.invert;

endmodule

// File: rtl/quint_timer.sv
module quint_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] tickEn,
  output logic [NUM_CH-1:0] irqOut,
  output logic [NUM_CH-1:0] toggleOut
);

  chanCtl_t          chCtl   [NUM_CH];
  logic [CNT_W-1:0]  liveCnt [NUM_CH];
  logic [CNT_W-1:0]  cntBuf  [NUM_CH];
  logic [CNT_W-1:0]  cmpBuf  [NUM_CH];
  logic [NUM_CH-1:0] expire;
  logic [NUM_CH-1:0] irqEn;

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .expire   (expire),
    .liveCnt  (liveCnt),
    .cntBuf   (cntBuf),
    .cmpBuf   (cmpBuf),
    .chCtl    (chCtl),
    .rdData   (rdData),
    .irqEn    (irqEn),
    .irqOut   (irqOut)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    tmr_chan #(.CNT_W(CNT_W)) uChan (
      .clk       (clk),
      .rstN      (rstN),
      .ctl       (chCtl[c]),
      .wdata     (regWdata[CNT_W-1:0]),
      .tick      (tickEn[c]),
      .liveCnt   (liveCnt[c]),
      .cntBufQ   (cntBuf[c]),
      .cmpBufQ   (cmpBuf[c]),
      .expire    (expire[c]),
      .toggleOut (toggleOut[c])
    );
  end

endmodule

// File: rtl/quint_timer_chk.sv
module quint_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [NUM_CH-1:0] tickEn,
  input logic [NUM_CH-1:0] irqOut,
  input chanCtl_t          chCtl   [NUM_CH],
  input logic [CNT_W-1:0]  liveCnt [NUM_CH],
  input logic [CNT_W-1:0]  cntBuf  [NUM_CH],
  input logic [NUM_CH-1:0] expire,
  input logic [NUM_CH-1:0] irqEn
);

  logic wrIrq;
  assign wrIrq = regWr && (regAddr == ADDR_W'(ADDR_IRQ));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_LOAD_FROM_BUF: assert property (@(posedge clk) disable iff (!rstN)
      chCtl[c].manual |=> liveCnt[c] == $past(cntBuf[c])); // R3

    AST_DEC_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
      chCtl[c].start && !chCtl[c].manual && tickEn[c] && (liveCnt[c] != '0)
      |=> liveCnt[c] == $past(liveCnt[c]) - 1'b1); // R4

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
      !tickEn[c] && !chCtl[c].manual |=> $stable(liveCnt[c])); // R4

    AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rstN)
      expire[c] && !chCtl[c].autoRld |=> (liveCnt[c] == '0) && !expire[c]); // R5

    AST_RELOAD_OLD_BUF: assert property (@(posedge clk) disable iff (!rstN)
      expire[c] && chCtl[c].autoRld |=> liveCnt[c] == $past(cntBuf[c])); // R6

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqOut[c]) |-> $past(expire[c]) || $past(wrIrq)); // R8

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      wrIrq && regWdata[ST_LSB + c] && !expire[c] |=> !irqOut[c]); // R9

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      wrIrq && regWdata[ST_LSB + c] && regWdata[c] && expire[c] && irqEn[c]
      |=> irqOut[c]); // R10
  end

endmodule

bind quint_timer quint_timer_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .tickEn   (tickEn),
  .irqOut   (irqOut),
  .chCtl    (chCtl),
  .liveCnt  (liveCnt),
  .cntBuf   (cntBuf),
  .expire   (expire),
  .irqEn    (irqEn)
);

// File: tb/tb_quint_timer.sv
module tb_quint_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  logic              clk;
  logic              rstN;
  logic              regWr;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] regWdata;
  logic [DATA_W-1:0] rdData;
  logic [4:0]        tickEn;
  logic [4:0]        irqOut;
  logic [4:0]        toggleOut;

  int nChecks = 0;
  int nFail   = 0;

  quint_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .rdData(rdData), .tickEn(tickEn),
    .irqOut(irqOut), .toggleOut(toggleOut)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns at the falling edge after the capturing rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h08, v); check("R1 ctrl", v, 0);
    rd(8'h44, v); check("R1 irq word", v, 0);
    rd(8'h14, v); check("R1 live ch0", v, 0);
    check("R1 irqOut", 32'(irqOut), 0);
    check("R1 toggleOut", 32'(toggleOut), 0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R2 ctrl readback mask", v, 32'h007F_FF0F);
    wr(8'h08, 0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R12 truncated reload buffer", v, 32'h0000_FFFF);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(8'h24, 32'h55); wr(8'h28, 32'h22); wr(8'h3C, 32'h77); wr(8'h40, 32'h99);
    rd(8'h24, v); check("R7 ch2 reload buffer", v, 32'h55);
    rd(8'h28, v); check("R7 ch2 compare buffer", v, 32'h22);
    rd(8'h3C, v); check("R7 ch4 reload buffer", v, 32'h77);
    rd(8'h40, v); check("R7 ch4 live ignores write", v, 0);
    wr(8'h08, 32'h0020_0000);
    idle(1);
    rd(8'h40, v); check("R3 ch4 load from buffer", v, 32'h77);
    wr(8'h20, 32'h1234);
    rd(8'h20, v); check("R7 ch1 live ignores write", v, 0);
    wr(8'h08, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(8'h44, 32'h001);
    wr(8'h0C, 3);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h1);
    rd(8'h14, v); check("R4 count starts at buffer", v, 3);
    idle(1);
    rd(8'h14, v); check("R4 decrement", v, 2);
    idle(2);
    rd(8'h14, v); check("R4 reached zero", v, 0);
    check("R8 no irq before expiry", 32'(irqOut[0]), 0);
    idle(1);
    check("R8 irq on expiry", 32'(irqOut[0]), 1);
    rd(8'h44, v); check("R8 status bit position", v, 32'h21);
    idle(5);
    rd(8'h14, v); check("R5 one-shot parks at zero", v, 0);
    wr(8'h44, 32'h21);
    check("R9 clear by write one", 32'(irqOut[0]), 0);
    idle(8);
    check("R5 no second expiry", 32'(irqOut[0]), 0);
  endtask

  task automatic t_tick();
    logic [31:0] v;
    wr(8'h0C, 10);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h9);
    tickEn[0] = 1'b0;
    idle(4);
    rd(8'h14, v); check("R4 hold without tick", v, 10);
    tickEn[0] = 1'b1;
    idle(3);
    rd(8'h14, v); check("R4 count with tick", v, 7);
    wr(8'h08, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(8'h44, 32'h3E2);
    wr(8'h18, 4);
    wr(8'h1C, 2);
    wr(8'h08, 32'h600);
    idle(1);
    check("R11 invert while loading", 32'(toggleOut[1]), 1);
    rd(8'h20, v); check("R3 ch1 loaded", v, 4);
    wr(8'h08, 32'h200);
    check("R11 invert cleared", 32'(toggleOut[1]), 0);
    wr(8'h08, 32'h900);
    idle(1);
    check("R11 low above compare", 32'(toggleOut[1]), 0);
    idle(1);
    rd(8'h20, v); check("R4 ch1 at compare", v, 2);
    check("R11 high at compare", 32'(toggleOut[1]), 1);
    idle(2);
    check("R8 ch1 no irq yet", 32'(irqOut[1]), 0);
    idle(1);
    rd(8'h20, v); check("R6 reload value", v, 4);
    check("R11 low after reload", 32'(toggleOut[1]), 0);
    check("R6 ch1 irq on expiry", 32'(irqOut[1]), 1);
    idle(5);
    rd(8'h20, v); check("R6 period of N+1 ticks", v, 4);
  endtask

  task automatic t_ch4();
    logic [31:0] v;
    wr(8'h44, 32'h3F0);
    wr(8'h3C, 2);
    wr(8'h08, 32'h0020_0000);
    wr(8'h08, 32'h0050_0000);
    rd(8'h40, v); check("R2 ch4 run bits", v, 2);
    idle(2);
    rd(8'h40, v); check("R4 ch4 reached zero", v, 0);
    check("R11 ch4 fixed compare zero", 32'(toggleOut[4]), 1);
    idle(1);
    rd(8'h40, v); check("R6 ch4 reload via bit 22", v, 2);
    check("R8 ch4 irq", 32'(irqOut[4]), 1);
    check("R11 ch4 low after reload", 32'(toggleOut[4]), 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(8'h08, 0);
    wr(8'h44, 32'h3E1);
    wr(8'h0C, 3);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h1);
    idle(2);
    wr(8'h44, 32'h21);
    check("R10 expiry beats clear", 32'(irqOut[0]), 1);
    wr(8'h44, 32'h01);
    check("R9 zero leaves status", 32'(irqOut[0]), 1);
    wr(8'h44, 32'h1E);
    rd(8'h44, v); check("R9 enables written directly", v, 32'h3E);
    check("R8 irq needs enable", 32'(irqOut[0]), 0);
    wr(8'h44, 32'h20);
    rd(8'h44, v); check("R9 status cleared", v, 0);
  endtask

  task automatic t_noen();
    logic [31:0] v;
    wr(8'h0C, 1);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h1);
    idle(4);
    rd(8'h44, v); check("R8 disabled expiry sets no status", v, 0);
    check("R8 disabled irq low", 32'(irqOut[0]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWr = 1'b0; regAddr = '0; regWdata = '0; tickEn = 5'h1F;
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_layout();
    t_map();
    t_oneshot();
    t_tick();
    t_periodic();
    t_ch4();
    t_w1c();
    t_noen();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule